// File: doc/BRIEF.md
# Pipelined ADC Sample Capture

This block sits between the parallel output of a 14-bit pipelined analog-to-digital converter and the digital datapath that uses the samples. The converter runs its sample clock at half the rate of its own clock. On each data-valid strobe it presents a 14-bit two's complement word and an out-of-range bit. The block takes one word on each rising edge of that strobe. It then throws away the words that the converter pipeline still owes from before output was enabled or before a calibration ended. It also converts the word to a 16-bit format chosen by a mode pin, and passes the samples on as a valid/ready stream.

The block drives the converter's output-enable from a local enable request. While the converter's outputs are disabled, during a short settling time after they are enabled again, and while a calibration is running, the strobe is ignored. After enable or after a calibration, a fixed number of qualified strobes are dropped to flush stale pipeline contents. A two-entry output stage absorbs short stalls of the consumer. A sample that finds both entries occupied is lost and sets a sticky overflow flag. A saturating counter tallies the accepted samples that carried the out-of-range bit. One clear pulse resets both this counter and the overflow flag.

Top module: `adc_capture`

## Requirements
- R1: After reset, m_valid_o, oe_o, overflow_o and oor_count_o are all 0.
- R2: oe_o equals enable_i as sampled on the previous clock edge.
- R3: A sample is taken only on a clock edge where dav_i is 1 and was 0 on the previous edge. Holding dav_i high for several cycles yields one sample.
- R4: Strobes are ignored while oe_o is 0, and also for SETTLE (default 3) clock cycles after oe_o becomes 1.
- R5: After oe_o rises, the first LATENCY (default 4) strobes that pass R4 are discarded.
- R6: Strobes are ignored while cal_busy_i is 1. After it falls, the first LATENCY qualifying strobes are discarded.
- R7: With fmt_i = 0 the output is the input sign-extended to 16 bits: 0x1FFF gives 0x1FFF, 0x2000 gives 0xE000, 0x0001 gives 0x0001.
- R8: With fmt_i = 1 the output is offset binary, made by inverting bit 13 and zero-extending: 0x1FFF gives 0x3FFF, 0x2000 gives 0x0000, 0x0000 gives 0x2000.
- R9: m_oor_o carries the out-of-range bit that arrived with the same sample.
- R10: oor_count_o increases by one for each accepted sample whose out-of-range bit is 1, and saturates at its all-ones value.
- R11: A cycle with clr_i = 1 sets oor_count_o and overflow_o to 0 on the next edge. The clear wins over a simultaneous increment or overflow.
- R12: While m_valid_o is 1 and m_ready_i is 0, m_data_o and m_oor_o hold steady. Up to two samples are kept in order.
- R13: A sample accepted while two samples are held and no transfer takes place is dropped, and overflow_o becomes 1 and stays 1 until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Request to enable the converter outputs |
| cal_busy_i | input | 1 | Calibration in progress |
| fmt_i | input | 1 | 0: sign-extended two's complement, 1: offset binary |
| clr_i | input | 1 | Clears the out-of-range counter and the overflow flag |
| dav_i | input | 1 | Data-valid strobe from the converter |
| data_i | input | 14 | Converter word, two's complement, bit 13 is the MSB |
| oor_i | input | 1 | Out-of-range bit from the converter |
| oe_o | output | 1 | Output-enable to the converter |
| m_valid_o | output | 1 | Stream sample valid |
| m_ready_i | input | 1 | Stream consumer ready |
| m_data_o | output | 16 | Formatted sample |
| m_oor_o | output | 1 | Out-of-range bit of the sample |
| oor_count_o | output | 16 | Saturating count of out-of-range samples |
| overflow_o | output | 1 | Sticky flag: a sample was lost |

## Verification
The hardest state to reach is a strobe edge that arrives exactly as an ignore window closes. The settling window after enable, the flush count and the fall of calibration-busy all have to line up at that edge. The bench raises enable and starts a strobe on the next edge, so strobes fall inside, at the end of, and after the settling window. It then checks exactly which words come out. Overflow needs the output stage full while the consumer stalls. The bench therefore holds ready low across three accepted strobes. Saturation is reached quickly by building the bench copy with an 8-bit counter.

// File: rtl/adc_capture_pkg.sv
package adc_capture_pkg;
  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } fmt_e;
endpackage

// File: rtl/adc_strobe_qual.sv
module adc_strobe_qual #(
  parameter int LATENCY = 4,
  parameter int SETTLE  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dav_i,
  input  logic oe_i,
  input  logic cal_busy_i,
  output logic take_o
);
  localparam int DW = $clog2(LATENCY + 2);
  localparam int SW = $clog2(SETTLE + 2);

  logic          dav_q;
  logic [SW-1:0] settle_q;
  logic [DW-1:0] drop_q;
  logic          qual;

  assign qual   = dav_i & ~dav_q & oe_i & ~cal_busy_i & (settle_q == '0);
  assign take_o = qual & (drop_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dav_q    <= 1'b0;
      settle_q <= SW'(SETTLE);
      drop_q   <= DW'(LATENCY);
    end else begin
      dav_q <= dav_i;
      if (!oe_i) settle_q <= SW'(SETTLE);
      else if (settle_q != '0) settle_q <= settle_q - 1'b1;
      // flush count re-arms on disable or calibration
      if (!oe_i || cal_busy_i) drop_q <= DW'(LATENCY);
      else if (qual && drop_q != '0) drop_q <= drop_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_fmt.sv
module adc_fmt #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 16
) (
  input  logic             offset_i,
  input  logic [IN_W-1:0]  din_i,
  output logic [OUT_W-1:0] dout_o
);
  localparam int EXT = OUT_W - IN_W;

  logic [IN_W-1:0] flipped;
  assign flipped = {~din_i[IN_W-1], din_i[IN_W-2:0]};

  generate
    if (EXT > 0) begin : g_ext
      always_comb begin
        if (offset_i) dout_o = {{EXT{1'b0}}, flipped};
        else          dout_o = {{EXT{din_i[IN_W-1]}}, din_i};
      end
    end else begin : g_same
      assign dout_o = offset_i ? flipped : din_i;
    end
  endgenerate
endmodule

// File: rtl/adc_skid.sv
module adc_skid #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o,
  output logic         lost_o
);
  logic [1:0]   cnt_q;
  logic [W-1:0] head_q, skid_q;
  logic         pop;

  assign valid_o = (cnt_q != 2'd0);
  assign dout_o  = head_q;
  assign pop     = valid_o & ready_i;
  assign lost_o  = push_i & (cnt_q == 2'd2) & ~pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= 2'd0;
      head_q <= '0;
      skid_q <= '0;
    end else begin
      unique case (cnt_q)
        2'd0: if (push_i) begin
          head_q <= din_i;
          cnt_q  <= 2'd1;
        end
        2'd1: begin
          if (push_i && pop) head_q <= din_i;
          else if (push_i) begin
            skid_q <= din_i;
            cnt_q  <= 2'd2;
          end else if (pop) cnt_q <= 2'd0;
        end
        default: if (pop) begin
          head_q <= skid_q;
          if (push_i) skid_q <= din_i;
          else        cnt_q  <= 2'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_oor_cnt.sv
module adc_oor_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         lost_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (inc_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
      if (lost_i) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_capture.sv
module adc_capture
  import adc_capture_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int OUT_W   = 16,
  parameter int CNT_W   = 16,
  parameter int LATENCY = 4,
  parameter int SETTLE  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              cal_busy_i,
  input  logic              fmt_i,
  input  logic              clr_i,
  input  logic              dav_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              oor_i,
  output logic              oe_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [OUT_W-1:0]  m_data_o,
  output logic              m_oor_o,
  output logic [CNT_W-1:0]  oor_count_o,
  output logic              overflow_o
);
  localparam int EW = OUT_W + 1;

  fmt_e             fmt;
  logic             take, lost;
  logic [OUT_W-1:0] fmt_data;
  logic [EW-1:0]    head;

  assign fmt = fmt_e'(fmt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_o <= 1'b0;
    else         oe_o <= enable_i;
  end

  adc_strobe_qual #(.LATENCY(LATENCY), .SETTLE(SETTLE)) u_qual (
    .clk_i, .rst_ni, .dav_i, .oe_i(oe_o), .cal_busy_i, .take_o(take)
  );

  adc_fmt #(.IN_W(DATA_W), .OUT_W(OUT_W)) u_fmt (
    .offset_i(fmt == FMT_OFFSET), .din_i(data_i), .dout_o(fmt_data)
  );

  adc_skid #(.W(EW)) u_skid (
    .clk_i, .rst_ni, .push_i(take), .din_i({oor_i, fmt_data}),
    .ready_i(m_ready_i), .valid_o(m_valid_o), .dout_o(head), .lost_o(lost)
  );

  assign m_oor_o  = head[EW-1];
  assign m_data_o = head[OUT_W-1:0];

  adc_oor_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(take & oor_i), .lost_i(lost), .clr_i,
    .cnt_o(oor_count_o), .ovf_o(overflow_o)
  );
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
  parameter int OUT_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             cal_busy_i,
  input logic             clr_i,
  input logic             oe_o,
  input logic             m_valid_o,
  input logic             m_ready_i,
  input logic [OUT_W-1:0] m_data_o,
  input logic             m_oor_o,
  input logic [CNT_W-1:0] oor_count_o,
  input logic             overflow_o
);
  p_oe_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> oe_o == $past(enable_i));

  p_off_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_o && !m_valid_o) |=> !m_valid_o);

  p_cal_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_busy_i && !m_valid_o) |=> !m_valid_o);

  p_cnt_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (oor_count_o >= $past(oor_count_o)) &&
               (oor_count_o - $past(oor_count_o) <= CNT_W'(1)));

  p_cnt_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oor_count_o == '1 && !clr_i) |=> oor_count_o == '1);

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (oor_count_o == '0) && !overflow_o);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> m_valid_o && $stable(m_data_o) && $stable(m_oor_o));

  p_ovf_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr_i) |=> overflow_o);
endmodule

bind adc_capture adc_capture_chk #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .cal_busy_i(cal_busy_i),
  .clr_i(clr_i), .oe_o(oe_o), .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
  .m_data_o(m_data_o), .m_oor_o(m_oor_o), .oor_count_o(oor_count_o),
  .overflow_o(overflow_o)
);

// File: tb/adc_capture_test.sv
`timescale 1ns/1ps
module adc_capture_test;
  localparam int LAT = 4;
  localparam int SET = 3;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, cal = 1'b0, fmt = 1'b0, clr = 1'b0;
  logic dav = 1'b0, oor = 1'b0, ready = 1'b1;
  logic [13:0] data = '0;
  logic oe, m_valid, m_oor, ovf;
  logic [15:0] m_data;
  logic [CW-1:0] cnt;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  adc_capture #(.CNT_W(CW), .LATENCY(LAT), .SETTLE(SET)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .cal_busy_i(cal),
    .fmt_i(fmt), .clr_i(clr), .dav_i(dav), .data_i(data), .oor_i(oor),
    .oe_o(oe), .m_valid_o(m_valid), .m_ready_i(ready), .m_data_o(m_data),
    .m_oor_o(m_oor), .oor_count_o(cnt), .overflow_o(ovf)
  );

  // behavioural reference
  logic [16:0] mq[$];
  logic [16:0] got[$];
  int  m_settle, m_drop, m_cnt;
  bit  m_oe, m_ovf, m_dav;

  function automatic logic [16:0] fmt_word(logic [13:0] d, logic f, logic o);
    int v;
    if (f) return {o, 2'b00, d ^ 14'h2000};
    v = (d >= 8192) ? int'(d) - 16384 : int'(d);
    return {o, 16'(v)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete(); m_settle = SET; m_drop = LAT; m_cnt = 0;
      m_oe = 0; m_ovf = 0; m_dav = 0;
    end else begin
      bit pop, qual, take;
      if (m_valid && ready) got.push_back({m_oor, m_data});
      pop  = (mq.size() != 0) && ready;
      qual = dav && !m_dav && m_oe && !cal && (m_settle == 0);
      take = qual && (m_drop == 0);
      if (pop) void'(mq.pop_front());
      if (take) begin
        if (mq.size() < 2) mq.push_back(fmt_word(data, fmt, oor));
        else m_ovf = 1;
        if (oor && m_cnt < (1 << CW) - 1) m_cnt++;
      end
      if (clr) begin m_cnt = 0; m_ovf = 0; end
      if (!m_oe) m_settle = SET; else if (m_settle > 0) m_settle--;
      if (!m_oe || cal) m_drop = LAT; else if (qual && m_drop > 0) m_drop--;
      m_oe = enable;
      m_dav = dav;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R12 valid", 32'(m_valid), 32'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk("R12 data", 32'(m_data), 32'(mq[0][15:0]));
      chk("R9 oor flag", 32'(m_oor), 32'(mq[0][16]));
    end
    chk("R2 oe", 32'(oe), 32'(m_oe));
    chk("R10 count", 32'(cnt), 32'(m_cnt));
    chk("R13 overflow", 32'(ovf), 32'(m_ovf));
  end

  always @(posedge clk) if (cyc == 60000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic strobe(logic [13:0] d, logic o);
    dav = 1'b1; data = d; oor = o;
    @(negedge clk);
    dav = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_got(string tag, int n, logic [16:0] e0, logic [16:0] e1);
    chk({tag, " count"}, 32'(got.size()), 32'(n));
    if (n > 0 && got.size() > 0) chk(tag, 32'(got[0]), 32'(e0));
    if (n > 1 && got.size() > 1) chk(tag, 32'(got[1]), 32'(e1));
    got.delete();
  endtask

  initial begin
    idle(2);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(m_valid), 0);
    chk("R1 oe", 32'(oe), 0);
    chk("R1 count", 32'(cnt), 0);
    chk("R1 overflow", 32'(ovf), 0);

    // R4 strobes while disabled
    strobe(14'h0011, 1'b0); strobe(14'h0012, 1'b0);
    idle(2);
    chk_got("R4 disabled", 0, '0, '0);

    // R4/R5 enable, settle window, then flush of LATENCY strobes
    enable = 1'b1;
    for (int i = 1; i <= 8; i++) strobe(14'(i), 1'b0);
    idle(3);
    chk("R2 oe high", 32'(oe), 1);
    chk_got("R5 flush", 2, 17'h00007, 17'h00008);

    // R7 sign extension
    strobe(14'h1FFF, 1'b0); strobe(14'h2000, 1'b0);
    idle(2);
    chk_got("R7 fullscale", 2, 17'h01FFF, 17'h0E000);
    strobe(14'h0001, 1'b0);
    idle(2);
    chk_got("R7 one", 1, 17'h00001, '0);

    // R8 offset binary
    fmt = 1'b1;
    strobe(14'h1FFF, 1'b0); strobe(14'h2000, 1'b0);
    idle(2);
    chk_got("R8 fullscale", 2, 17'h03FFF, 17'h00000);
    strobe(14'h0000, 1'b0);
    idle(2);
    chk_got("R8 zero", 1, 17'h02000, '0);
    fmt = 1'b0;

    // R9/R10 out-of-range flag and count
    strobe(14'h0100, 1'b1);
    idle(2);
    chk_got("R9 flagged", 1, 17'h10100, '0);
    chk("R10 one", 32'(cnt), 1);

    // R3 long strobe gives one sample
    dav = 1'b1; data = 14'h0033; oor = 1'b0;
    idle(4);
    dav = 1'b0;
    idle(3);
    chk_got("R3 level", 1, 17'h00033, '0);

    // R6 calibration
    cal = 1'b1;
    strobe(14'h0044, 1'b0); strobe(14'h0045, 1'b0);
    idle(2);
    chk_got("R6 busy", 0, '0, '0);
    cal = 1'b0;
    for (int i = 1; i <= 6; i++) strobe(14'h0050 + 14'(i), 1'b0);
    idle(2);
    chk_got("R6 flush", 2, 17'h00055, 17'h00056);

    // R12/R13 stall and overflow
    ready = 1'b0;
    strobe(14'h0061, 1'b0); strobe(14'h0062, 1'b0); strobe(14'h0063, 1'b1);
    idle(2);
    chk("R12 held", 32'(m_data), 32'h0061);
    chk("R13 flag", 32'(ovf), 1);
    chk("R10 dropped oor still counted", 32'(cnt), 2);
    ready = 1'b1;
    idle(3);
    chk_got("R12 order", 2, 17'h00061, 17'h00062);
    chk("R13 sticky", 32'(ovf), 1);

    // R11 clear
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
    chk("R11 count", 32'(cnt), 0);
    chk("R11 overflow", 32'(ovf), 0);

    // R10 saturation
    for (int i = 0; i < 260; i++) strobe(14'(i), 1'b1);
    idle(2);
    chk("R10 saturated", 32'(cnt), 32'(255));
    got.delete();

    // R4 disable again
    enable = 1'b0;
    idle(1);
    strobe(14'h0077, 1'b0); strobe(14'h0078, 1'b0);
    idle(2);
    chk("R2 oe low", 32'(oe), 0);
    chk_got("R4 disabled again", 0, '0, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule